// File: doc/BRIEF.md
# Interrupt Destination Resolver

The resolver takes one routed interrupt request and works out which of up to 32 attached local interrupt controllers should receive it. The request carries a destination value, a destination-mode bit (physical or logical) and a three-bit delivery mode. Each attached controller contributes an 8-bit physical identifier, the upper byte of its logical-destination register and the top nibble of its destination-format register. Physical requests match on identifier equality. Logical requests match per controller, in either flat or cluster style, as that controller's own format nibble selects.

The resolver then applies the delivery mode. Fixed and external delivery send to every matched controller. Lowest-priority delivery picks a single controller from the matched set with a rotating pointer, so that repeated requests spread over the candidates. Delivery modes for system-management, non-maskable, init and startup messages are not handled. They yield no targets and raise a flag. The result is registered and appears on the cycle after the request as a target vector with a valid bit, plus flags for a bad format nibble and an unsupported mode.

Top module: `irq_dest_resolver`

## Requirements
- R1: In physical mode (`req_logical`=0) at most one target bit is set: the lowest-numbered attached controller whose identifier equals `req_dest`. If no attached controller has that identifier, no bit is set.
- R2: A logical request with `req_dest` equal to 0 gives an empty target vector.
- R3: In logical mode, a controller whose format nibble is 4'hF is matched flat: it is a target when `req_dest` AND its logical byte is nonzero.
- R4: In logical mode, a controller whose format nibble is 4'h0 is matched by cluster. The upper nibble of its logical byte must equal `req_dest[7:4]`, and the lower nibble of its logical byte ANDed with `req_dest[3:0]` must be nonzero.
- R5: A logical request with a nonzero destination never matches an attached controller whose format nibble is any value other than 4'hF or 4'h0, and `out_fmt_err` is then 1. Controllers that are not attached raise no error.
- R6: Delivery modes 3'd0 (fixed) and 3'd7 (external) set every matched target bit.
- R7: Delivery mode 3'd1 (lowest priority) sets exactly one target. The resolver searches from a rotating pointer and picks the first matched controller at or after the pointer, wrapping past the last index. The pointer then moves to one past the pick. The pointer is 0 after reset.
- R8: Delivery modes 3'd2, 3'd3, 3'd4, 3'd5 and 3'd6 give no targets, `out_valid`=0 and `out_unsup`=1.
- R9: Only controllers with index below `tgt_count` can be targets.
- R10: When the matched set is empty, `out_valid` is 0 and the lowest-priority pointer keeps its value.
- R11: Outputs are registered. A request presented on one rising edge shows its result after that edge. A cycle without `req_valid` gives all outputs 0, and reset clears all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_dest | input | 8 | Destination value |
| req_logical | input | 1 | 1 = logical destination mode, 0 = physical |
| req_dmode | input | 3 | Delivery mode code |
| tgt_count | input | 6 | Number of attached controllers (0..32) |
| tgt_phys_id | input | 256 | Physical identifier per controller, 8 bits each, controller i at [8i+7:8i] |
| tgt_logical | input | 256 | Logical-destination byte per controller, 8 bits each |
| tgt_format | input | 128 | Format nibble per controller, 4 bits each |
| out_valid | output | 1 | At least one target selected |
| out_targets | output | 32 | Selected target vector |
| out_fmt_err | output | 1 | An attached controller had an unusable format nibble |
| out_unsup | output | 1 | Delivery mode not supported |

## Verification
Physical requests use duplicate identifiers, an identifier that no attached controller has, and identifiers that match only among unattached controllers. These cases separate lowest-index selection from the broadcast of every match and confirm the attach limit. Logical requests go against all-flat, all-cluster and mixed controller sets, with destinations chosen so that flat and cluster rules would give different answers. A bad format nibble appears both inside and outside the attached range. Lowest-priority sequences drive the pointer through wrap-around, through a single-member set, past unattached indices and through an empty set, so that a rotation error, a pointer that moves when it should not and a fixed-priority pick each give a different target than expected.

// File: rtl/irq_dest_pkg.sv
package irq_dest_pkg;

  typedef enum logic [2:0] {
    DM_FIXED    = 3'd0,
    DM_LOWEST   = 3'd1,
    DM_SYSMGMT  = 3'd2,
    DM_RSVD     = 3'd3,
    DM_NONMASK  = 3'd4,
    DM_INIT     = 3'd5,
    DM_START    = 3'd6,
    DM_EXTERNAL = 3'd7
  } dmode_e;

  localparam logic [3:0] FMT_FLAT    = 4'hF;
  localparam logic [3:0] FMT_CLUSTER = 4'h0;

  function automatic logic mode_supported(input dmode_e m);
    return (m == DM_FIXED) || (m == DM_LOWEST) || (m == DM_EXTERNAL);
  endfunction

endpackage

// File: rtl/irq_dest_match.sv
module irq_dest_match
  import irq_dest_pkg::*;
#(
  parameter int DEST_W = 8
) (
  input  logic              attached,
  input  logic              logical,
  input  logic [DEST_W-1:0] dest,
  input  logic [DEST_W-1:0] phys_id,
  input  logic [DEST_W-1:0] ldr_byte,
  input  logic [3:0]        fmt,
  output logic              hit,
  output logic              fmt_bad
);

  localparam int HALF = DEST_W / 2;

  logic dest_nz;
  logic flat_hit;
  logic clu_hit;
  logic log_hit;

  always_comb begin
    dest_nz  = |dest;
    flat_hit = |(dest & ldr_byte);
    clu_hit  = (ldr_byte[DEST_W-1:HALF] == dest[DEST_W-1:HALF]) &&
               (|(ldr_byte[HALF-1:0] & dest[HALF-1:0]));
    unique case (fmt)
      FMT_FLAT:    log_hit = flat_hit;
      FMT_CLUSTER: log_hit = clu_hit;
      default:     log_hit = 1'b0;
    endcase
    if (logical) begin
      hit     = attached && dest_nz && log_hit;
      fmt_bad = attached && dest_nz && (fmt != FMT_FLAT) && (fmt != FMT_CLUSTER);
    end else begin
      hit     = attached && (phys_id == dest);
      fmt_bad = 1'b0;
    end
  end

  // R5
  always_comb begin
    bad_fmt_nohit_chk: assert (!(fmt_bad && hit));
  end

endmodule

// File: rtl/irq_dest_rr_pick.sv
module irq_dest_rr_pick #(
  parameter int N_TGT = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_en,
  input  logic [N_TGT-1:0] mask,
  output logic [N_TGT-1:0] pick
);

  localparam int IDX_W = (N_TGT > 1) ? $clog2(N_TGT) : 1;

  logic [IDX_W-1:0] ptr_q;
  logic [IDX_W-1:0] ptr_d;
  logic [IDX_W-1:0] pick_idx;
  logic             found;
  logic             ptr_en;

  always_comb begin
    int unsigned idx;
    found    = 1'b0;
    pick_idx = '0;
    for (int k = 0; k < N_TGT; k++) begin
      idx = int'(ptr_q) + k;
      if (idx >= N_TGT) idx = idx - N_TGT;
      if (!found && mask[idx[IDX_W-1:0]]) begin
        found    = 1'b1;
        pick_idx = idx[IDX_W-1:0];
      end
    end
    pick = found ? (N_TGT'(1) << pick_idx) : '0;
  end

  always_comb begin
    ptr_en = adv_en && found;
    if (pick_idx == IDX_W'(N_TGT - 1)) ptr_d = '0;
    else                               ptr_d = pick_idx + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  // R10
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_en && (mask == '0)) |=> $stable(ptr_q));

  // R7
  pick_in_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pick & ~mask) == '0) && $onehot0(pick));

endmodule

// File: rtl/irq_dest_resolver.sv
module irq_dest_resolver
  import irq_dest_pkg::*;
#(
  parameter int N_TGT  = 32,
  parameter int DEST_W = 8,
  localparam int CNT_W = $clog2(N_TGT + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic [DEST_W-1:0]       req_dest,
  input  logic                    req_logical,
  input  logic [2:0]              req_dmode,
  input  logic [CNT_W-1:0]        tgt_count,
  input  logic [N_TGT*DEST_W-1:0] tgt_phys_id,
  input  logic [N_TGT*DEST_W-1:0] tgt_logical,
  input  logic [N_TGT*4-1:0]      tgt_format,
  output logic                    out_valid,
  output logic [N_TGT-1:0]        out_targets,
  output logic                    out_fmt_err,
  output logic                    out_unsup
);

  dmode_e           mode;
  logic [N_TGT-1:0] attached;
  logic [N_TGT-1:0] hit_vec;
  logic [N_TGT-1:0] bad_vec;
  logic [N_TGT-1:0] mask;
  logic [N_TGT-1:0] rr_pick;
  logic             supported;
  logic             rr_adv;

  logic [N_TGT-1:0] tgt_d;
  logic             valid_d;
  logic             err_d;
  logic             unsup_d;
  logic             out_en;

  assign mode = dmode_e'(req_dmode);

  for (genvar i = 0; i < N_TGT; i++) begin : g_tgt
    assign attached[i] = (tgt_count > CNT_W'(i));
    irq_dest_match #(.DEST_W(DEST_W)) u_match (
      .attached (attached[i]),
      .logical  (req_logical),
      .dest     (req_dest),
      .phys_id  (tgt_phys_id[i*DEST_W +: DEST_W]),
      .ldr_byte (tgt_logical[i*DEST_W +: DEST_W]),
      .fmt      (tgt_format[i*4 +: 4]),
      .hit      (hit_vec[i]),
      .fmt_bad  (bad_vec[i])
    );
  end

  // physical mode keeps only the lowest-numbered hit
  always_comb begin
    if (req_logical) mask = hit_vec;
    else             mask = hit_vec & (~hit_vec + N_TGT'(1));
    supported = mode_supported(mode);
    rr_adv    = req_valid && (mode == DM_LOWEST);
  end

  irq_dest_rr_pick #(.N_TGT(N_TGT)) u_rr (
    .clk    (clk),
    .rst_n  (rst_n),
    .adv_en (rr_adv),
    .mask   (mask),
    .pick   (rr_pick)
  );

  always_comb begin
    if (!req_valid || !supported) tgt_d = '0;
    else if (mode == DM_LOWEST)   tgt_d = rr_pick;
    else                          tgt_d = mask;
    valid_d = |tgt_d;
    err_d   = req_valid && (|bad_vec);
    unsup_d = req_valid && !supported;
    out_en  = req_valid || out_valid || out_fmt_err || out_unsup;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_targets <= '0;
      out_valid   <= 1'b0;
      out_fmt_err <= 1'b0;
      out_unsup   <= 1'b0;
    end else if (out_en) begin
      out_targets <= tgt_d;
      out_valid   <= valid_d;
      out_fmt_err <= err_d;
      out_unsup   <= unsup_d;
    end
  end

  // R1
  phys_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_logical) |=> $onehot0(out_targets));

  // R2
  zero_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_logical && (req_dest == '0)) |=> (out_targets == '0) && !out_valid);

  // R7
  lowest_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_dmode == 3'd1)) |=> $onehot0(out_targets));

  // R8
  unsup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !mode_supported(mode)) |=> out_unsup && !out_valid && (out_targets == '0));

  // R9
  attach_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> ((out_targets & ~$past(attached)) == '0));

  // R11
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !out_valid && (out_targets == '0) && !out_fmt_err && !out_unsup);

endmodule

// File: tb/irq_dest_resolver_bench.sv
module irq_dest_resolver_bench;

  localparam int CLK_PERIOD = 10;
  localparam int N = 32;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           req_valid;
  logic [7:0]     req_dest;
  logic           req_logical;
  logic [2:0]     req_dmode;
  logic [5:0]     tgt_count;
  logic [N*8-1:0] tgt_phys_id;
  logic [N*8-1:0] tgt_logical;
  logic [N*4-1:0] tgt_format;
  logic           out_valid;
  logic [N-1:0]   out_targets;
  logic           out_fmt_err;
  logic           out_unsup;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_dest_resolver u_irq_dest_resolver (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_dest(req_dest),
    .req_logical(req_logical), .req_dmode(req_dmode), .tgt_count(tgt_count),
    .tgt_phys_id(tgt_phys_id), .tgt_logical(tgt_logical), .tgt_format(tgt_format),
    .out_valid(out_valid), .out_targets(out_targets),
    .out_fmt_err(out_fmt_err), .out_unsup(out_unsup)
  );

  task automatic check(input string tag, input logic [N-1:0] et, input logic ev,
                       input logic ee, input logic eu);
    n_chk++;
    if (out_targets !== et || out_valid !== ev || out_fmt_err !== ee || out_unsup !== eu) begin
      n_bad++;
      $display("FAIL %s: got t=%h v=%b e=%b u=%b exp t=%h v=%b e=%b u=%b",
               tag, out_targets, out_valid, out_fmt_err, out_unsup, et, ev, ee, eu);
    end
  endtask

  task automatic set_tgt(input int i, input logic [7:0] id, input logic [7:0] lb,
                         input logic [3:0] f);
    tgt_phys_id[i*8 +: 8] = id;
    tgt_logical[i*8 +: 8] = lb;
    tgt_format[i*4 +: 4]  = f;
  endtask

  task automatic defaults();
    for (int i = 0; i < N; i++) set_tgt(i, 8'd5, 8'hFF, 4'hF);
  endtask

  // called at a falling edge; returns at the next falling edge with result visible
  task automatic send(input logic [7:0] d, input logic lg, input logic [2:0] m);
    req_valid = 1'b1; req_dest = d; req_logical = lg; req_dmode = m;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; req_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    check("R11 reset", '0, 0, 0, 0);
  endtask

  task automatic t_physical();
    defaults(); tgt_count = 6'd4;
    set_tgt(0, 8'd5, 8'hFF, 4'hF); set_tgt(1, 8'd7, 8'hFF, 4'hF);
    set_tgt(2, 8'd5, 8'hFF, 4'hF); set_tgt(3, 8'd9, 8'hFF, 4'hF);
    send(8'd5, 0, 3'd0); check("R1 dup id lowest index", 32'h1, 1, 0, 0);
    send(8'd9, 0, 3'd0); check("R1 id 9", 32'h8, 1, 0, 0);
    send(8'd3, 0, 3'd0); check("R10 phys no match", '0, 0, 0, 0);
    req_valid = 1'b0; @(negedge clk);
    check("R11 idle cycle", '0, 0, 0, 0);
  endtask

  task automatic t_flat();
    defaults(); tgt_count = 6'd4;
    set_tgt(0, 8'd5, 8'h01, 4'hF); set_tgt(1, 8'd7, 8'h02, 4'hF);
    set_tgt(2, 8'd5, 8'h04, 4'hF); set_tgt(3, 8'd9, 8'h03, 4'hF);
    send(8'h02, 1, 3'd0); check("R3 R6 flat fixed", 32'hA, 1, 0, 0);
    send(8'h05, 1, 3'd7); check("R3 R6 flat external", 32'hD, 1, 0, 0);
    send(8'h00, 1, 3'd0); check("R2 logical dest zero", '0, 0, 0, 0);
  endtask

  task automatic t_cluster();
    defaults(); tgt_count = 6'd4;
    set_tgt(0, 8'd5, 8'h21, 4'h0); set_tgt(1, 8'd7, 8'h22, 4'h0);
    set_tgt(2, 8'd5, 8'h31, 4'h0); set_tgt(3, 8'd9, 8'h23, 4'h0);
    send(8'h23, 1, 3'd0); check("R4 cluster 2", 32'hB, 1, 0, 0);
    send(8'h31, 1, 3'd0); check("R4 cluster 3", 32'h4, 1, 0, 0);
    send(8'h24, 1, 3'd0); check("R4 no member bits", '0, 0, 0, 0);
  endtask

  task automatic t_mixed();
    defaults(); tgt_count = 6'd4;
    set_tgt(0, 8'd5, 8'h21, 4'hF); set_tgt(1, 8'd7, 8'h21, 4'h0);
    set_tgt(2, 8'd5, 8'hFF, 4'h5); set_tgt(3, 8'd9, 8'h31, 4'h0);
    send(8'h21, 1, 3'd0); check("R5 mixed formats, bad one flagged", 32'h3, 1, 1, 0);
    tgt_count = 6'd2;
    send(8'h21, 1, 3'd0); check("R5 bad format unattached", 32'h3, 1, 0, 0);
  endtask

  task automatic t_attach();
    defaults(); tgt_count = 6'd2;
    send(8'hFF, 1, 3'd0); check("R9 logical limited", 32'h3, 1, 0, 0);
    tgt_count = 6'd0;
    send(8'hFF, 1, 3'd0); check("R9 none attached", '0, 0, 0, 0);
    tgt_count = 6'd2;
    set_tgt(0, 8'd1, 8'hFF, 4'hF); set_tgt(1, 8'd2, 8'hFF, 4'hF);
    send(8'd5, 0, 3'd0); check("R9 phys match only unattached", '0, 0, 0, 0);
    tgt_count = 6'd32;
    send(8'd5, 0, 3'd0); check("R1 R9 full count", 32'h4, 1, 0, 0);
  endtask

  task automatic t_lowest();
    do_reset();
    defaults(); tgt_count = 6'd4;
    set_tgt(0, 8'd5, 8'hFF, 4'hF); set_tgt(1, 8'd7, 8'hFF, 4'hF);
    set_tgt(2, 8'd5, 8'hFF, 4'hF); set_tgt(3, 8'd9, 8'hFF, 4'hF);
    send(8'h0F, 1, 3'd1); check("R7 first pick", 32'h1, 1, 0, 0);
    send(8'h0F, 1, 3'd1); check("R7 rotate", 32'h2, 1, 0, 0);
    send(8'd5, 0, 3'd1);  check("R7 wrap single member", 32'h1, 1, 0, 0);
    send(8'h00, 1, 3'd1); check("R10 empty lowest", '0, 0, 0, 0);
    send(8'h0F, 1, 3'd1); check("R10 pointer held", 32'h2, 1, 0, 0);
    set_tgt(0, 8'd5, 8'h01, 4'hF); set_tgt(1, 8'd7, 8'h02, 4'hF);
    set_tgt(2, 8'd5, 8'h02, 4'hF); set_tgt(3, 8'd9, 8'h01, 4'hF);
    send(8'h01, 1, 3'd0); check("R6 fixed all", 32'h9, 1, 0, 0);
    send(8'h01, 1, 3'd1); check("R7 at or after pointer", 32'h8, 1, 0, 0);
    send(8'h01, 1, 3'd1); check("R7 wrap past unattached", 32'h1, 1, 0, 0);
  endtask

  task automatic t_unsup();
    defaults(); tgt_count = 6'd4;
    for (int m = 2; m <= 6; m++) begin
      send(8'd5, 0, 3'(m)); check($sformatf("R8 mode %0d", m), '0, 0, 0, 1);
    end
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_dest = '0; req_logical = 1'b0;
    req_dmode = '0; tgt_count = '0;
    tgt_phys_id = '0; tgt_logical = '0; tgt_format = '0;
    @(negedge clk);
    t_reset();
    t_physical();
    t_flat();
    t_cluster();
    t_mixed();
    t_attach();
    t_unsup();
    t_lowest();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule